// File: doc/BRIEF.md
# Supply Impedance Sweep Sequencer

This block runs an on-chip measurement of the impedance of a supply rail. It uses the frequency of a free-running oscillator that shares that rail. For each measurement point it counts oscillator rising edges over a programmable gate window twice. The first count is taken with an external current load switched off, giving the baseline count N. The second is taken straight after with the load switched on, giving the loaded count M. The impedance figure is then the relative frequency shift times a programmable scale. The scale stands for the supply voltage divided by the test current, so the figure is |M − N| × scale / N, with a separate sign flag.

A sweep walks through up to sixteen load frequency words held in a small register array. The word for the current point is presented to the load while the load is on, and each point's result is stored in a result array. Every result is also streamed out with a one-cycle valid strobe. A remote controller drives a simple register port. It writes the window length, the scale, the frequency words and a start command, then polls status and reads the stored profile. Outside a requested sweep the load stays off.

Top module: `pdn_sweep_seq`

## Requirements
- R1: After reset the status word reads 0 (busy bit 0, done bit 1 and error bit 2 all clear), the gate length register reads 0, `load_en` is low and `res_valid` is low.
- R2: Register map on `reg_addr`. Address 0x01 holds the gate length in cycles (24 bits). Address 0x02 holds the scale (24 bits). Addresses 0x10+i hold frequency word i (16 bits). Addresses 0x20+i read result i as {error bit 25, negative bit 24, magnitude 23:0}. Address 0x00 reads status with busy in bit 0, done in bit 1, any-error in bit 2 and the last point index in bits 7:4. Written values read back unchanged.
- R3: Each count is the number of `osc_in` rising edges seen through a two-flop synchroniser while its window is open. The count stops at 2^24−1 rather than wrapping.
- R4: For each point `load_en` is high for exactly gate-length consecutive cycles, right after a baseline window of the same length. It is never high while no sweep is running.
- R5: The result magnitude is floor(|M − N| × scale / N). The negative flag is 1 exactly when M < N.
- R6: When the baseline count N is 0 the division is skipped. The result then has error flag 1, magnitude 0 and negative flag 0, and status bit 2 sets.
- R7: Writing address 0x00 with bit 0 set and bits 7:4 = L starts a sweep of points 0..L in ascending order. `res_valid` pulses for one cycle per point with `res_index` equal to the point. After the last point, done sets and busy clears.
- R8: While `load_en` is high, `load_freq` equals the frequency word of the point being measured.
- R9: A magnitude that does not fit in 24 bits is reported as 0xFFFFFF.
- R10: While a sweep is busy every register write is ignored, including a second start command and gate or scale changes.
- R11: The quotient is formed by a restoring divider that produces one bit per cycle, whose partial remainder always stays below the divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Asynchronous oscillator signal from the supply-sensing ring |
| load_en | output | 1 | Switches the external current load on |
| load_freq | output | 16 | Frequency word for the external load |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| res_valid | output | 1 | One-cycle strobe for a finished point |
| res_index | output | 4 | Index of the finished point |
| res_mag | output | 24 | Impedance magnitude of the finished point |
| res_neg | output | 1 | Loaded count was below baseline |
| res_err | output | 1 | Baseline count was zero |

## Verification
The divider checks assume it is launched only with a non-zero divisor. The sequencer guarantees this by skipping the division on a zero baseline, and the bench reaches that path only through a silent oscillator. The synchroniser checks assume every level of `osc_in` lasts at least two clock cycles. The bench oscillator changes on falling clock edges with half-periods of two cycles or more, and its gate lengths are multiples of the oscillator period. That keeps the baseline count exact, but the loaded count may be off by a small amount at the load switch-over, so impedance magnitudes are checked against a range built from neighbouring counts. Register writes are single-cycle strobes driven away from the active edge.

// File: rtl/pdn_sweep_pkg.sv
package pdn_sweep_pkg;

    localparam int CNT_W   = 24;
    localparam int SCL_W   = 24;
    localparam int FRQ_W   = 16;
    localparam int MAX_PTS = 16;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int PROD_W  = CNT_W + SCL_W;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_GATE  = 6'h01;
    localparam logic [ADDR_W-1:0] A_SCALE = 6'h02;
    localparam logic [1:0] BANK_CFG = 2'b00;
    localparam logic [1:0] BANK_FRQ = 2'b01;
    localparam logic [1:0] BANK_RES = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BASE, ST_LOADED, ST_DIV, ST_SAVE, ST_STEP
    } seq_state_e;

    typedef struct packed {
        logic             err;
        logic             neg;
        logic [CNT_W-1:0] mag;
    } point_res_t;

    function automatic logic [CNT_W-1:0] clip_mag(input logic [PROD_W-1:0] q);
        if (|q[PROD_W-1:CNT_W]) return '1;
        return q[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic osc_async,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], osc_async};
    end

    assign rise = sh[1] & ~sh[2];

    // R3: a detected edge is a single-cycle pulse
    assert_rise_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/sat_gate_counter.sv
module sat_gate_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)                  cnt <= '0;
        else if (en && inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == TOP) |=> cnt == TOP);
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    assert_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(cnt));
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [CW-1:0]    left;
    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   trial;
    logic             busy;

    assign busy   = (left != '0);
    assign rem_sh = {rem, quo[NUM_W-1]};
    assign trial  = rem_sh - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            quo   <= '0;
            den_q <= '0;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem   <= '0;
                quo   <= num;
                den_q <= den;
                left  <= CW'(NUM_W);
            end else if (busy) begin
                if (!trial[DEN_W]) begin
                    rem <= trial[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= rem_sh[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b0};
                end
                left <= left - 1'b1;
                if (left == CW'(1)) done <= 1'b1;
            end
        end
    end

    assert_rem_below_den_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> rem < den_q);
    assert_den_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |-> den != '0);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/pdn_sweep_seq.sv
module pdn_sweep_seq
    import pdn_sweep_pkg::*;
#(
    parameter int POINTS = MAX_PTS,
    parameter int IDX_W  = $clog2(MAX_PTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_in,
    output logic              load_en,
    output logic [FRQ_W-1:0]  load_freq,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_index,
    output logic [CNT_W-1:0]  res_mag,
    output logic              res_neg,
    output logic              res_err
);
    localparam int RES_W = $bits(point_res_t);

    seq_state_e       st;
    logic [CNT_W-1:0] gate_len;
    logic [CNT_W-1:0] win;
    logic [SCL_W-1:0] scale;
    logic [FRQ_W-1:0] frq_mem [POINTS];
    point_res_t       res_mem [POINTS];
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] ra;
    logic             done_f;
    logic             err_any;
    logic             launched;
    point_res_t       cur;

    logic             osc_rise;
    logic [CNT_W-1:0] cnt_nom;
    logic [CNT_W-1:0] cnt_mod;
    logic [CNT_W-1:0] diff_mag;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] div_quo;
    logic             div_done;
    logic             div_go;
    logic             mod_lt;
    logic             running;
    logic             start_req;
    logic             win_end;
    logic             last_pt;
    logic             new_point;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:CNT_W];

    assign running   = (st != ST_IDLE);
    assign ra        = reg_addr[IDX_W-1:0];
    assign start_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[0] && !running;
    assign win_end   = ({1'b0, win} + 1'b1) >= {1'b0, gate_len};
    assign last_pt   = (idx == last_idx);
    assign new_point = start_req || (st == ST_STEP && !last_pt);

    osc_edge_sync u_sync (
        .clk(clk), .rst(rst), .osc_async(osc_in), .rise(osc_rise)
    );

    sat_gate_counter #(.W(CNT_W)) u_cnt_nom (
        .clk(clk), .rst(rst), .clr(new_point), .en(st == ST_BASE),
        .inc(osc_rise), .cnt(cnt_nom)
    );

    sat_gate_counter #(.W(CNT_W)) u_cnt_mod (
        .clk(clk), .rst(rst), .clr(new_point), .en(st == ST_LOADED),
        .inc(osc_rise), .cnt(cnt_mod)
    );

    assign mod_lt   = (cnt_mod < cnt_nom);
    assign diff_mag = mod_lt ? (cnt_nom - cnt_mod) : (cnt_mod - cnt_nom);
    assign prod     = PROD_W'(diff_mag) * PROD_W'(scale);
    assign div_go   = (st == ST_DIV) && !launched && (cnt_nom != '0);

    restoring_div #(.NUM_W(PROD_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(prod), .den(cnt_nom),
        .done(div_done), .quo(div_quo)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            win      <= '0;
            idx      <= '0;
            last_idx <= '0;
            done_f   <= 1'b0;
            err_any  <= 1'b0;
            launched <= 1'b0;
            cur      <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start_req) begin
                    st       <= ST_BASE;
                    win      <= '0;
                    idx      <= '0;
                    last_idx <= reg_wdata[4 +: IDX_W];
                    done_f   <= 1'b0;
                    err_any  <= 1'b0;
                end
                ST_BASE: begin
                    if (win_end) begin
                        st  <= ST_LOADED;
                        win <= '0;
                    end else win <= win + 1'b1;
                end
                ST_LOADED: begin
                    launched <= 1'b0;
                    if (win_end) begin
                        st  <= ST_DIV;
                        win <= '0;
                    end else win <= win + 1'b1;
                end
                ST_DIV: begin
                    if (cnt_nom == '0) begin
                        cur.err <= 1'b1;
                        cur.neg <= 1'b0;
                        cur.mag <= '0;
                        st      <= ST_SAVE;
                    end else begin
                        launched <= 1'b1;
                        if (div_done) begin
                            cur.err <= 1'b0;
                            cur.neg <= mod_lt;
                            cur.mag <= clip_mag(div_quo);
                            st      <= ST_SAVE;
                        end
                    end
                end
                ST_SAVE: begin
                    err_any <= err_any | cur.err;
                    st      <= ST_STEP;
                end
                ST_STEP: begin
                    if (last_pt) begin
                        st     <= ST_IDLE;
                        done_f <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                        win <= '0;
                        st  <= ST_BASE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Register storage: configuration only while idle, results from the sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_len <= '0;
            scale    <= '0;
            for (int i = 0; i < POINTS; i++) begin
                frq_mem[i] <= '0;
                res_mem[i] <= '0;
            end
        end else begin
            if (reg_we && !running) begin
                if (reg_addr == A_GATE)  gate_len <= reg_wdata[CNT_W-1:0];
                if (reg_addr == A_SCALE) scale    <= reg_wdata[SCL_W-1:0];
                if (reg_addr[5:4] == BANK_FRQ) frq_mem[ra] <= reg_wdata[FRQ_W-1:0];
            end
            if (st == ST_SAVE) res_mem[idx] <= cur;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr[5:4])
            BANK_CFG: begin
                if (reg_addr == A_CTRL) begin
                    reg_rdata[0]          = running;
                    reg_rdata[1]          = done_f;
                    reg_rdata[2]          = err_any;
                    reg_rdata[4 +: IDX_W] = last_idx;
                end else if (reg_addr == A_GATE) begin
                    reg_rdata[CNT_W-1:0] = gate_len;
                end else if (reg_addr == A_SCALE) begin
                    reg_rdata[SCL_W-1:0] = scale;
                end
            end
            BANK_FRQ: reg_rdata[FRQ_W-1:0] = frq_mem[ra];
            BANK_RES: reg_rdata[RES_W-1:0] = res_mem[ra];
            default:  reg_rdata = '0;
        endcase
    end

    assign load_en   = (st == ST_LOADED);
    assign load_freq = frq_mem[idx];
    assign res_valid = (st == ST_SAVE);
    assign res_index = idx;
    assign res_mag   = cur.mag;
    assign res_neg   = cur.neg;
    assign res_err   = cur.err;

    assert_load_fresh_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(load_en) |-> cnt_mod == '0);
    assert_load_only_running_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !done_f);
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_f |-> !running);
    assert_err_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err) |-> (res_mag == '0 && !res_neg));
    assert_ignore_busy_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> ($stable(gate_len) && $stable(scale)));
endmodule

// File: tb/pdn_sweep_seq_bench.sv
module pdn_sweep_seq_bench;
    import pdn_sweep_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc = 1'b0;
    logic        load_en;
    logic [15:0] load_freq;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        res_valid;
    logic [3:0]  res_index;
    logic [23:0] res_mag;
    logic        res_neg;
    logic        res_err;

    always #2 clk = ~clk;

    pdn_sweep_seq u_pdn_sweep_seq (
        .clk(clk), .rst(rst), .osc_in(osc), .load_en(load_en), .load_freq(load_freq),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_valid(res_valid), .res_index(res_index), .res_mag(res_mag),
        .res_neg(res_neg), .res_err(res_err)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // Oscillator model: half-period in clock cycles, 0 holds it low
    int half_nom = 0;
    int half_mod = 0;
    int ph = 0;
    always begin
        @(negedge clk);
        begin
            int h;
            h = load_en ? half_mod : half_nom;
            if (h == 0) begin
                osc = 1'b0;
                ph  = 0;
            end else begin
                ph++;
                if (ph >= h) begin
                    ph  = 0;
                    osc = ~osc;
                end
            end
        end
    end

    // Output monitor
    int          got_n = 0;
    int          load_cyc = 0;
    int          frq_bad = 0;
    int          idle_bad = 0;
    bit          run_on = 1'b0;
    logic [15:0] exp_frq [16];
    int          got_idx [16];
    logic [25:0] got_res [16];

    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid && got_n < 16) begin
                got_idx[got_n] = int'(res_index);
                got_res[got_n] = {res_err, res_neg, res_mag};
                got_n++;
            end
            if (load_en) begin
                load_cyc++;
                if (!run_on) idle_bad++;
                if (got_n < 16 && load_freq != exp_frq[got_n]) frq_bad++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what,
                           input longint act, input longint lo, input longint hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Expected magnitude range from counts near the ideal values
    task automatic exp_range(input longint n, input longint m, input longint scl,
                             output longint lo, output longint hi);
        lo = 64'h7fffffffffffffff;
        hi = 0;
        for (longint dn = -1; dn <= 1; dn++) begin
            for (longint dm = -2; dm <= 2; dm++) begin
                longint nn, mm, q;
                nn = n + dn;
                mm = m + dm;
                if (nn > 0 && mm >= 0) begin
                    q = ((mm > nn) ? (mm - nn) : (nn - mm)) * scl / nn;
                    if (q > 64'hFFFFFF) q = 64'hFFFFFF;
                    if (q < lo) lo = q;
                    if (q > hi) hi = q;
                end
            end
        end
    endtask

    task automatic start_sweep(input int last);
        got_n    = 0;
        load_cyc = 0;
        frq_bad  = 0;
        run_on   = 1'b1;
        reg_wr(A_CTRL, 32'((last << 4) | 1));
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(A_CTRL, s);
            if (s[1]) break;
        end
        repeat (4) @(negedge clk);
        run_on = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(A_CTRL, d);
        chk(d == 0, "R1", "status", d, 0);
        reg_rd(A_GATE, d);
        chk(d == 0, "R1", "gate", d, 0);
        chk(load_en == 1'b0, "R1", "load_en", load_en, 0);
        chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_wr(A_GATE, 32'd256);
        reg_wr(A_SCALE, 32'd1000);
        for (int i = 0; i < 4; i++) begin
            exp_frq[i] = 16'h1000 + 16'(i * 16'h0111);
            reg_wr(6'h10 + 6'(i), {16'h0, exp_frq[i]});
        end
        reg_rd(A_GATE, d);
        chk(d == 256, "R2", "gate readback", d, 256);
        reg_rd(A_SCALE, d);
        chk(d == 1000, "R2", "scale readback", d, 1000);
        reg_rd(6'h12, d);
        chk(d == {16'h0, exp_frq[2]}, "R2", "freq word 2", d, exp_frq[2]);
    endtask

    task automatic t_positive();
        longint lo, hi;
        logic [31:0] d;
        half_nom = 4; half_mod = 2;
        start_sweep(0);
        wait_done();
        exp_range(32, 64, 1000, lo, hi);
        chk(got_n == 1, "R7", "result count", got_n, 1);
        chk_rng("R5", "magnitude up shift (R11 divider)", got_res[0][23:0], lo, hi);
        chk(got_res[0][24] == 1'b0, "R5", "sign up shift", got_res[0][24], 0);
        chk(load_cyc == 256, "R4", "load cycles", load_cyc, 256);
        chk(frq_bad == 0, "R8", "freq word mismatches", frq_bad, 0);
        reg_rd(A_CTRL, d);
        chk(d[2:0] == 3'b010, "R7", "status after sweep", d[2:0], 2);
    endtask

    task automatic t_negative();
        longint lo, hi;
        half_nom = 2; half_mod = 4;
        start_sweep(0);
        wait_done();
        exp_range(64, 32, 1000, lo, hi);
        chk_rng("R5", "magnitude down shift", got_res[0][23:0], lo, hi);
        chk(got_res[0][24] == 1'b1, "R5", "sign down shift", got_res[0][24], 1);
        chk(got_res[0][25] == 1'b0, "R6", "no error", got_res[0][25], 0);
    endtask

    task automatic t_zero_shift();
        half_nom = 4; half_mod = 4;
        start_sweep(0);
        wait_done();
        chk(got_res[0] == 26'h0, "R5", "equal counts give zero", got_res[0], 0);
    endtask

    task automatic t_no_osc();
        logic [31:0] d;
        half_nom = 0; half_mod = 0;
        start_sweep(0);
        wait_done();
        chk(got_res[0] == {2'b10, 24'h0}, "R6", "zero baseline result", got_res[0], 26'h2000000);
        reg_rd(A_CTRL, d);
        chk(d[2] == 1'b1, "R6", "status error bit", d[2], 1);
    endtask

    task automatic t_sweep();
        longint lo, hi;
        logic [31:0] d;
        half_nom = 4; half_mod = 2;
        exp_range(32, 64, 1000, lo, hi);
        start_sweep(3);
        wait_done();
        chk(got_n == 4, "R7", "sweep result count", got_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk(got_idx[i] == i, "R7", "point order", got_idx[i], i);
            chk_rng("R5", "sweep magnitude", got_res[i][23:0], lo, hi);
            reg_rd(6'h20 + 6'(i), d);
            chk(d[25:0] == got_res[i], "R2", "stored result", d[25:0], got_res[i]);
        end
        chk(load_cyc == 4 * 256, "R4", "sweep load cycles", load_cyc, 1024);
        chk(frq_bad == 0, "R8", "sweep freq words", frq_bad, 0);
        reg_rd(A_CTRL, d);
        chk(d[7:0] == 8'h32, "R7", "status done last=3", d[7:0], 8'h32);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        reg_wr(A_SCALE, 32'hFFFFFF);
        half_nom = 64; half_mod = 2;
        start_sweep(0);
        wait_done();
        chk(got_res[0][23:0] == 24'hFFFFFF, "R9", "saturated magnitude", got_res[0][23:0], 24'hFFFFFF);
        reg_rd(A_CTRL, d);
        chk(d[2] == 1'b0, "R6", "error bit cleared by new sweep", d[2], 0);
        reg_wr(A_SCALE, 32'd1000);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        half_nom = 4; half_mod = 2;
        start_sweep(1);
        repeat (40) @(negedge clk);
        reg_wr(A_CTRL, 32'h51);
        reg_wr(A_GATE, 32'd16);
        wait_done();
        chk(got_n == 2, "R10", "restart ignored", got_n, 2);
        chk(load_cyc == 512, "R10", "gate change ignored", load_cyc, 512);
        reg_rd(A_GATE, d);
        chk(d == 256, "R10", "gate readback", d, 256);
        reg_rd(A_CTRL, d);
        chk(d[7:4] == 4'd1, "R10", "last index kept", d[7:4], 1);
        chk(idle_bad == 0, "R4", "load while idle", idle_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_frq[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_positive();
        t_negative();
        t_zero_shift();
        t_no_osc();
        t_sweep();
        t_saturate();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule